// File: doc/BRIEF.md
# Programmable-Degree Multilinear Extension Engine

This block turns a pair of multilinear table entries for one variable, the value at 0 and the value at 1, into the evaluations of that linear polynomial at the integer points 0, 1, ..., d. The prime field uses modular adders and subtractors only, and there are no multipliers. The engine forms the difference between the two entries once. It then adds that difference to a running value on every cycle, starting from the value at 0. The result stream feeds a product stage that needs d+1 points per table pair, where d is the degree of the gate being proven.

The degree is written through a configuration strobe while the engine is idle, and it can change from one gate to the next. Degrees above 31 cannot be held in the local register file downstream. A registered spill flag reports this case. The engine still emits every point. Pairs arrive on a valid/ready handshake. The first round carries one table pair (two values). Later rounds carry two pairs (four values), and the two lanes are extended side by side under a per-lane enable. Each output beat carries its point index, and a last flag marks the beat for index d.

Top module: `mle_ext_engine`

## Requirements
- R1: After reset the engine is idle: out_valid=0, in_ready=1, out_lane_vld=0, the degree is DEG_RST (default 1) and spill=0.
- R2: A pair accepted on a clock edge (in_valid and in_ready both 1) produces beats on the d+1 consecutive cycles that follow that edge. out_idx runs 0, 1, ..., d, where d is the configured degree.
- R3: For an enabled lane, the beat with index k carries (f0 + k*(f1 - f0)) mod P, with all inputs below P. Lane n takes f0 from in_f0[n*W +: W] and f1 from in_f1[n*W +: W].
- R4: out_last is 1 on the beat with index d and 0 on every other beat.
- R5: in_ready is 0 from the accepting edge until the last beat has been issued, and it is 1 again in the cycle after the last beat.
- R6: spill is 1 exactly when the configured degree is greater than 31. It updates on the edge that takes the configuration write.
- R7: A configuration write while beats are being issued is ignored. The current pair and the pairs after it keep the old degree, and spill does not change.
- R8: If a configuration write and a pair acceptance happen on the same edge while the engine is idle, the new degree applies to that pair.
- R9: in_lane_en bit n is captured with the pair. While beats are issued, out_lane_vld[n] equals that captured bit. out_lane_vld is 0 whenever out_valid is 0.
- R10: A degree of 0 gives a single beat with index 0, value f0 and out_last=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Degree write strobe, taken only when idle |
| cfg_deg | input | DEG_W | Degree value to write |
| spill | output | 1 | Configured degree exceeds the register limit |
| in_valid | input | 1 | Table pair offered |
| in_ready | output | 1 | Engine can take a pair |
| in_lane_en | input | LANES | Lanes that carry a pair |
| in_f0 | input | LANES*W | Per-lane table value at 0 |
| in_f1 | input | LANES*W | Per-lane table value at 1 |
| out_valid | output | 1 | Evaluation beat present |
| out_idx | output | DEG_W | Point index of the beat |
| out_last | output | 1 | Beat is the final point d |
| out_lane_vld | output | LANES | Lanes whose evaluation is meaningful |
| out_eval | output | LANES*W | Per-lane evaluation at out_idx |

## Verification
Two functions can land on the same edge: a degree write and a pair acceptance. One case is a write and an offered pair together while the engine is idle. The bench drives both on the same cycle and expects the stream to run to the new degree. The other case is a write that arrives while a stream is running, one beat after it starts. The bench expects that stream and the next one to end at the old degree, and expects spill to stay unchanged even when the ignored value would have set it.

// File: rtl/mle_ext_pkg.sv
package mle_ext_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // True when a degree cannot be held in the local registers.
  function automatic logic deg_spills(input int unsigned deg, input int unsigned lim);
    return deg > lim;
  endfunction

endpackage

// File: rtl/mle_ext_cfg.sv
module mle_ext_cfg #(
  parameter int unsigned DEG_W   = 6,
  parameter int unsigned REG_LIM = 31,
  parameter int unsigned DEG_RST = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_take,
  input  logic [DEG_W-1:0] wr_deg,
  output logic [DEG_W-1:0] deg,
  output logic             spill
);
  localparam logic [DEG_W-1:0] DEG_INIT   = DEG_W'(DEG_RST);
  localparam logic             SPILL_INIT = mle_ext_pkg::deg_spills(DEG_RST, REG_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deg   <= DEG_INIT;
      spill <= SPILL_INIT;
    end else if (wr_take) begin
      deg   <= wr_deg;
      spill <= mle_ext_pkg::deg_spills(int'(wr_deg), REG_LIM);
    end
  end
endmodule

// File: rtl/mle_ext_seq.sv
module mle_ext_seq #(
  parameter int unsigned DEG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DEG_W-1:0] deg,
  output logic             busy,
  output logic [DEG_W-1:0] idx,
  output logic             last,
  output logic             step
);
  import mle_ext_pkg::*;

  seq_state_e state_q;

  assign busy = (state_q == SEQ_RUN);
  assign last = busy && (idx == deg);
  assign step = busy && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx     <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_RUN;
          idx     <= '0;
        end
        SEQ_RUN: begin
          if (last) state_q <= SEQ_IDLE;
          else      idx     <= idx + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mle_ext_lane.sv
module mle_ext_lane #(
  parameter int unsigned W = 16,
  parameter int unsigned P = 65521
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         en_in,
  input  logic [W-1:0] f0,
  input  logic [W-1:0] f1,
  output logic [W-1:0] eval,
  output logic         en
);
  localparam logic [W:0] PM = (W+1)'(P);

  function automatic logic [W-1:0] fadd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= PM) s = s - PM;
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] fsub(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    if (a >= b) s = {1'b0, a} - {1'b0, b};
    else        s = {1'b0, a} + PM - {1'b0, b};
    return s[W-1:0];
  endfunction

  logic [W-1:0] diff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eval   <= '0;
      diff_q <= '0;
      en     <= 1'b0;
    end else if (load) begin
      eval   <= f0;
      diff_q <= fsub(f1, f0);
      en     <= en_in;
    end else if (step) begin
      eval   <= fadd(eval, diff_q);
    end
  end
endmodule

// File: rtl/mle_ext_engine.sv
module mle_ext_engine #(
  parameter int unsigned W       = 16,
  parameter int unsigned P       = 65521,
  parameter int unsigned LANES   = 2,
  parameter int unsigned DEG_W   = 6,
  parameter int unsigned REG_LIM = 31,
  parameter int unsigned DEG_RST = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [DEG_W-1:0]   cfg_deg,
  output logic               spill,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LANES-1:0]   in_lane_en,
  input  logic [LANES*W-1:0] in_f0,
  input  logic [LANES*W-1:0] in_f1,
  output logic               out_valid,
  output logic [DEG_W-1:0]   out_idx,
  output logic               out_last,
  output logic [LANES-1:0]   out_lane_vld,
  output logic [LANES*W-1:0] out_eval
);
  // Named internal events, also used by the bound checker.
  logic             busy;
  logic             accept_evt;
  logic             cfg_take_evt;
  logic             step_evt;
  logic             last_evt;
  logic [DEG_W-1:0] cur_deg;
  logic [LANES-1:0] lane_en_q;

  assign in_ready     = !busy;
  assign accept_evt   = in_valid && in_ready;
  assign cfg_take_evt = cfg_wr && !busy;

  mle_ext_cfg #(.DEG_W(DEG_W), .REG_LIM(REG_LIM), .DEG_RST(DEG_RST)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_take(cfg_take_evt), .wr_deg(cfg_deg),
    .deg(cur_deg), .spill(spill)
  );

  mle_ext_seq #(.DEG_W(DEG_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(accept_evt), .deg(cur_deg),
    .busy(busy), .idx(out_idx), .last(last_evt), .step(step_evt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mle_ext_lane #(.W(W), .P(P)) lane_i (
      .clk(clk), .rst_n(rst_n), .load(accept_evt), .step(step_evt),
      .en_in(in_lane_en[g]), .f0(in_f0[g*W +: W]), .f1(in_f1[g*W +: W]),
      .eval(out_eval[g*W +: W]), .en(lane_en_q[g])
    );
  end

  assign out_valid    = busy;
  assign out_last     = last_evt;
  assign out_lane_vld = lane_en_q & {LANES{busy}};
endmodule

// File: rtl/mle_ext_chk.sv
module mle_ext_chk #(
  parameter int unsigned DEG_W   = 6,
  parameter int unsigned REG_LIM = 31,
  parameter int unsigned LANES   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_last,
  input logic [DEG_W-1:0] out_idx,
  input logic [DEG_W-1:0] cur_deg,
  input logic             spill,
  input logic [LANES-1:0] out_lane_vld
);
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_idx == '0)); // R2

  AST_IDX_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && out_idx == DEG_W'($past(out_idx) + 1'b1))); // R2

  AST_LAST_AT_DEG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_idx == cur_deg)); // R4

  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R5

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> in_ready); // R5

  AST_SPILL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    spill == (int'(cur_deg) > REG_LIM)); // R6

  AST_DEG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> $stable(cur_deg)); // R7

  AST_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_lane_vld == '0)); // R9
endmodule

bind mle_ext_engine mle_ext_chk #(.DEG_W(DEG_W), .REG_LIM(REG_LIM), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_last(out_last), .out_idx(out_idx),
  .cur_deg(cur_deg), .spill(spill), .out_lane_vld(out_lane_vld)
);

// File: tb/mle_ext_engine_tb.sv
module mle_ext_engine_tb_top;
  localparam int W = 16;
  localparam int P = 65521;
  localparam int LANES = 2;
  localparam int DEG_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [DEG_W-1:0] cfg_deg = '0;
  logic spill;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES-1:0] in_lane_en = '0;
  logic [LANES*W-1:0] in_f0 = '0;
  logic [LANES*W-1:0] in_f1 = '0;
  logic out_valid;
  logic [DEG_W-1:0] out_idx;
  logic out_last;
  logic [LANES-1:0] out_lane_vld;
  logic [LANES*W-1:0] out_eval;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mle_ext_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_deg(cfg_deg), .spill(spill),
    .in_valid(in_valid), .in_ready(in_ready), .in_lane_en(in_lane_en),
    .in_f0(in_f0), .in_f1(in_f1), .out_valid(out_valid), .out_idx(out_idx),
    .out_last(out_last), .out_lane_vld(out_lane_vld), .out_eval(out_eval)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic longint expect_eval(input longint f0, input longint f1, input longint k);
    longint d;
    d = (f1 - f0 + P) % P;
    return (f0 + k * d) % P;
  endfunction

  task automatic set_deg(input int d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_deg = DEG_W'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(spill == (d > 31), "R6 spill after write", spill, (d > 31)); // R6
  endtask

  // Offer one pair and check every beat of the resulting stream.
  task automatic run_pair(input int f0a, input int f1a, input int f0b, input int f1b,
                          input bit [1:0] en, input int d,
                          input bit inj, input int inj_deg,
                          input bit same_cfg, input int same_deg);
    @(negedge clk);
    chk(in_ready == 1'b1, "R5 ready before pair", in_ready, 1);
    in_valid = 1'b1; in_lane_en = en;
    in_f0 = {W'(f0b), W'(f0a)}; in_f1 = {W'(f1b), W'(f1a)};
    if (same_cfg) begin cfg_wr = 1'b1; cfg_deg = DEG_W'(same_deg); end
    @(negedge clk);
    in_valid = 1'b0; cfg_wr = 1'b0;
    for (int k = 0; k <= d; k++) begin
      chk(out_valid == 1'b1, "R2 beat valid", out_valid, 1);
      chk(out_idx == DEG_W'(k), "R2 point index", out_idx, k);
      chk(out_last == (k == d), "R4 last flag", out_last, (k == d));
      chk(in_ready == 1'b0, "R5 ready low while issuing", in_ready, 0);
      chk(out_lane_vld == en, "R9 lane valid", out_lane_vld, en);
      if (en[0]) chk(longint'(out_eval[W-1:0]) == expect_eval(f0a, f1a, k),
                     "R3 lane0 eval", out_eval[W-1:0], expect_eval(f0a, f1a, k));
      if (en[1]) chk(longint'(out_eval[2*W-1:W]) == expect_eval(f0b, f1b, k),
                     "R3 lane1 eval", out_eval[2*W-1:W], expect_eval(f0b, f1b, k));
      if (inj && k == 0) begin cfg_wr = 1'b1; cfg_deg = DEG_W'(inj_deg); end
      @(negedge clk);
      cfg_wr = 1'b0;
    end
    chk(out_valid == 1'b0, "R2 stream ends after d+1 beats", out_valid, 0);
    chk(in_ready == 1'b1, "R5 ready after last beat", in_ready, 1);
    chk(out_lane_vld == 2'b00, "R9 lanes quiet when idle", out_lane_vld, 0);
  endtask

  task automatic t_reset; // R1
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(spill == 1'b0, "R1 spill after reset", spill, 0);
    chk(out_lane_vld == 2'b00, "R1 lanes after reset", out_lane_vld, 0);
    run_pair(10, 17, 0, 0, 2'b01, 1, 0, 0, 0, 0); // R1 reset degree 1
  endtask

  task automatic t_basic; // R2 R3 R4
    set_deg(5);
    run_pair(100, 130, 0, 0, 2'b01, 5, 0, 0, 0, 0);
    run_pair(500, 20, 0, 0, 2'b01, 5, 0, 0, 0, 0);
  endtask

  task automatic t_wrap; // R3 modular wrap in both directions
    set_deg(7);
    run_pair(P - 1, 3, 2, P - 2, 2'b01, 7, 0, 0, 0, 0);
    run_pair(P - 3, P - 1, 0, P - 1, 2'b11, 7, 0, 0, 0, 0);
  endtask

  task automatic t_dual; // R9
    set_deg(3);
    run_pair(1, 2, 40000, 9, 2'b11, 3, 0, 0, 0, 0);
    run_pair(0, 0, 7, 70, 2'b10, 3, 0, 0, 0, 0);
  endtask

  task automatic t_deg0; // R10
    set_deg(0);
    run_pair(4242, 99, 0, 0, 2'b01, 0, 0, 0, 0, 0);
  endtask

  task automatic t_spill; // R6 degrees around the limit
    set_deg(31);
    set_deg(32);
    set_deg(40);
    run_pair(12345, 54321, 3, 60000, 2'b11, 40, 0, 0, 0, 0);
    set_deg(2);
  endtask

  task automatic t_cfg_busy; // R7
    set_deg(3);
    run_pair(5, 8, 0, 0, 2'b01, 3, 1, 40, 0, 0);
    chk(spill == 1'b0, "R7 ignored write leaves spill", spill, 0);
    run_pair(6, 1, 0, 0, 2'b01, 3, 0, 0, 0, 0);
  endtask

  task automatic t_cfg_same; // R8
    set_deg(3);
    run_pair(9, 11, 0, 0, 2'b01, 6, 0, 0, 1, 6);
    run_pair(2, 3, 0, 0, 2'b01, 6, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_dual();
    t_deg0();
    t_spill();
    t_cfg_busy();
    t_cfg_same();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule